// File: doc/BRIEF.md
# Prescaled Memory Refresh Request Timer

This block paces refresh for a local memory controller that drives up to eight banks. A shared prescaler divides the system clock into ticks. Two independent 8-bit period timers count those ticks. One paces banks run by the programmable-sequence machine. The other paces banks run by the SDRAM machine. Each bank presents three configuration bits: valid, machine select and refresh enable. A bank qualifies for a timer only when all three bits agree with that timer.

The two timers react differently when they expire. An expiry of the programmable-machine timer refreshes exactly one qualified bank, and the choice rotates round-robin across expiries. An expiry of the SDRAM timer starts a round that covers every qualified bank. That round raises the requests one bank at a time in ascending order, and each next bank waits until the previous one has been accepted.

Every request line stays high until the controller pulses the matching accept line. Expiries that arrive while a request is still outstanding are counted, and they are served later. Software writes the prescaler and the two period values through simple write strobes. A new value takes effect only when the counter it governs next reaches terminal count.

Top module: `rfsh_req_timer`

## Requirements
- R1: The interval between expiries of a timer is its period value times the prescaler value, counted in system clock cycles. With a prescaler of 4 and a period of 3, requests rise every 12 cycles. With a prescaler of 32 and a period of 128, requests rise every 4096 cycles.
- R2: A period value of 0 stands for 256, and a prescaler value of 0 also stands for 256. After reset every value is 0, so the first expiry takes at least 256 prescaler terminal counts.
- R3: A written prescaler or period value is held in a shadow register. It becomes active only at the next terminal count of the counter it governs, and the interval running at the time of the write is left unchanged.
- R4: A bank qualifies for the programmable-machine timer only when all three of these hold: its valid bit is 1, its machine select bit is 0, and its refresh enable bit is 1.
- R5: Each programmable-machine expiry requests exactly one qualified bank. That bank is the next qualified bank after the one served last, counting upward with wrap-around and skipping banks that do not qualify. An expiry that finds no qualified bank produces no request.
- R6: A bank qualifies for the SDRAM timer only when all three of these hold: its valid bit is 1, its machine select bit is 1, and its refresh enable bit is 1.
- R7: Each SDRAM expiry requests every bank that qualified when the round began. The requests go out one bank at a time in ascending bank order, and the next one is raised only after the current one is accepted.
- R8: A request on line b stays high until refresh_ack[b] is high in a clock cycle. Accept pulses on lines that carry no request have no effect.
- R9: An expiry that occurs while a request from the same timer is outstanding is recorded, and it is served later. Up to 15 recorded expiries are kept per timer.
- R10: When rst_n is low at a clock edge, all counters, pending requests and recorded expiries are cleared. After reset no request is high, and the programmable-machine rotation begins with bank 0.
- R11: At any time at most one programmable-machine request and at most one SDRAM request are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_valid | input | 8 | Per-bank valid bit |
| bank_mach | input | 8 | Per-bank machine select: 0 selects the programmable machine, 1 selects the SDRAM machine |
| bank_refresh_en | input | 8 | Per-bank refresh enable |
| presc_wr | input | 1 | Write strobe for the prescaler value |
| presc_wdata | input | 8 | New prescaler value (0 means 256) |
| pgm_period_wr | input | 1 | Write strobe for the programmable-machine period |
| pgm_period_wdata | input | 8 | New programmable-machine period (0 means 256) |
| sd_period_wr | input | 1 | Write strobe for the SDRAM period |
| sd_period_wdata | input | 8 | New SDRAM period (0 means 256) |
| refresh_ack | input | 8 | Per-bank accept pulse for an outstanding request |
| refresh_req | output | 8 | Per-bank refresh request |

## Verification
The properties assume that a bank does not switch machine while one of its requests is outstanding. If it did, two issuers could claim the same line, and one accept would clear both. The stimulus therefore changes bank configuration only in cycles where refresh_req is all zero. Accepts come from a responder that pulses only the lowest requested line for a single cycle. A separate phase deliberately drives an accept on a line that never carries a request.

// File: rtl/rfsh_pkg.sv
// Shared definitions for the refresh request timer.
// Assumes one machine-select bit per bank.
package rfsh_pkg;

    // Encoding of the per-bank machine select bit
    typedef enum logic {
        MACH_PGM   = 1'b0,
        MACH_SDRAM = 1'b1
    } rfsh_mach_e;

endpackage

// File: rtl/rfsh_prescaler.sv
// Divides the system clock into a one-cycle tick every DIV cycles.
// DIV comes from an active register, where 0 stands for 2**W.
// Writes land in a shadow register. The shadow is copied into the active
// register only at terminal count, so a write never shortens or stretches
// the interval that is already running.
module rfsh_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         tick
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] shadow_q, active_q, count_q;

    // Terminal count: the active value minus one, which wraps to all ones for 0
    assign tick = (count_q == active_q - ONE);

    // Counter advance, terminal reload and shadow capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
            count_q  <= '0;
        end else begin
            if (wr) shadow_q <= wdata;
            if (tick) begin
                count_q  <= '0;
                active_q <= shadow_q;
            end else begin
                count_q  <= count_q + ONE;
            end
        end
    end
endmodule

// File: rtl/rfsh_period_timer.sv
// Counts prescaler ticks and flags an expiry on the tick that completes the
// period. Period 0 stands for 2**W. A written period is held in a shadow
// register and is loaded into the active register at the next expiry.
module rfsh_period_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] shadow_q, active_q, count_q;

    // Expiry occurs on the tick at which the count reaches its terminal value
    assign expire = tick && (count_q == active_q - ONE);

    // Tick counting, reload at expiry and shadow capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
            count_q  <= '0;
        end else begin
            if (wr) shadow_q <= wdata;
            if (expire) begin
                count_q  <= '0;
                active_q <= shadow_q;
            end else if (tick) begin
                count_q  <= count_q + ONE;
            end
        end
    end
endmodule

// File: rtl/rfsh_rr_issuer.sv
// Turns expiries into single-bank requests that rotate round-robin over the
// qualified banks. The search starts at the bank after the last one served.
// Expiries that find at least one qualified bank are counted in a saturating
// debt counter, so a busy period loses nothing.
// Assumes NB is at least 2.
module rfsh_rr_issuer #(
    parameter int NB = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expire,
    input  logic [NB-1:0] qual,
    input  logic [NB-1:0] ack,
    output logic [NB-1:0] req
);
    localparam int             IW       = $clog2(NB);
    localparam logic [DW-1:0]  DEBT_MAX = '1;
    localparam logic [DW-1:0]  DONE     = DW'(1);
    localparam logic [IW-1:0]  LAST     = IW'(NB - 1);

    logic          active_q;
    logic [IW-1:0] bank_q, last_q, pick, cand;
    logic [DW-1:0] debt_q;
    logic          any_q, launch, served, inc;

    assign any_q  = |qual;
    assign served = active_q && ack[bank_q];
    assign launch = !active_q && ((debt_q != '0) || expire) && any_q;
    assign inc    = expire && any_q;

    // Nearest qualified bank after the last one served (the loop runs downward so the nearest wins)
    always_comb begin
        pick = last_q;
        cand = last_q;
        for (int i = NB; i >= 1; i--) begin
            cand = IW'((int'(last_q) + i) % NB);
            if (qual[cand]) pick = cand;
        end
    end

    // Request state, rotation pointer and expiry debt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            bank_q   <= '0;
            last_q   <= LAST;
            debt_q   <= '0;
        end else begin
            if (served) active_q <= 1'b0;
            if (launch) begin
                active_q <= 1'b1;
                bank_q   <= pick;
                last_q   <= pick;
            end
            if (inc && !launch && debt_q != DEBT_MAX) debt_q <= debt_q + DONE;
            else if (launch && !inc)                  debt_q <= debt_q - DONE;
        end
    end

    // One-hot decode of the outstanding request
    for (genvar g = 0; g < NB; g++) begin : g_req
        assign req[g] = active_q && (bank_q == IW'(g));
    end
endmodule

// File: rtl/rfsh_stagger_issuer.sv
// Turns expiries into rounds that cover every qualified bank. A round
// snapshots the qualified mask and issues the lowest remaining bank. Each
// accept clears that bank and exposes the next higher one. Expiries that
// arrive during a round are counted and start later rounds.
module rfsh_stagger_issuer #(
    parameter int NB = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          expire,
    input  logic [NB-1:0] qual,
    input  logic [NB-1:0] ack,
    output logic [NB-1:0] req
);
    localparam logic [DW-1:0] DEBT_MAX = '1;
    localparam logic [DW-1:0] DONE     = DW'(1);
    localparam logic [NB-1:0] NONE     = NB'(1);

    logic [NB-1:0] round_q;
    logic [DW-1:0] debt_q;
    logic          launch, inc, served;

    assign req    = round_q & (~round_q + NONE);
    assign served = |(req & ack);
    assign launch = (round_q == '0) && ((debt_q != '0) || expire) && (|qual);
    assign inc    = expire && (|qual);

    // Round mask and expiry debt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            round_q <= '0;
            debt_q  <= '0;
        end else begin
            if (launch)      round_q <= qual;
            else if (served) round_q <= round_q & ~req;
            if (inc && !launch && debt_q != DEBT_MAX) debt_q <= debt_q + DONE;
            else if (launch && !inc)                  debt_q <= debt_q - DONE;
        end
    end
endmodule

// File: rtl/rfsh_req_timer.sv
// Top of the refresh request timer. One shared prescaler feeds two period
// timers. The programmable-machine timer drives a round-robin issuer, and
// the SDRAM timer drives a staggered issuer. Per-bank qualification selects
// which banks each issuer may request. The request lines of the two issuers
// are merged onto one output vector.
// Assumes a bank keeps its machine select while it has a request outstanding.
module rfsh_req_timer
    import rfsh_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int PRE_W     = 8,
    parameter int PER_W     = 8,
    parameter int DEBT_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_valid,
    input  logic [NUM_BANKS-1:0] bank_mach,
    input  logic [NUM_BANKS-1:0] bank_refresh_en,
    input  logic                 presc_wr,
    input  logic [PRE_W-1:0]     presc_wdata,
    input  logic                 pgm_period_wr,
    input  logic [PER_W-1:0]     pgm_period_wdata,
    input  logic                 sd_period_wr,
    input  logic [PER_W-1:0]     sd_period_wdata,
    input  logic [NUM_BANKS-1:0] refresh_ack,
    output logic [NUM_BANKS-1:0] refresh_req
);
    logic                 tick, pgm_expire, sd_expire;
    logic [NUM_BANKS-1:0] pgm_qual, sd_qual, pgm_req, sd_req;

    // Per-bank qualification for each machine
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_qual
        assign pgm_qual[b] = bank_valid[b] && bank_refresh_en[b] && (bank_mach[b] == MACH_PGM);
        assign sd_qual[b]  = bank_valid[b] && bank_refresh_en[b] && (bank_mach[b] == MACH_SDRAM);
    end

    rfsh_prescaler #(.W(PRE_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .wr(presc_wr), .wdata(presc_wdata), .tick(tick)
    );

    rfsh_period_timer #(.W(PER_W)) pgm_tmr_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr(pgm_period_wr),
        .wdata(pgm_period_wdata), .expire(pgm_expire)
    );

    rfsh_period_timer #(.W(PER_W)) sd_tmr_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr(sd_period_wr),
        .wdata(sd_period_wdata), .expire(sd_expire)
    );

    rfsh_rr_issuer #(.NB(NUM_BANKS), .DW(DEBT_W)) pgm_iss_i (
        .clk(clk), .rst_n(rst_n), .expire(pgm_expire), .qual(pgm_qual),
        .ack(refresh_ack), .req(pgm_req)
    );

    rfsh_stagger_issuer #(.NB(NUM_BANKS), .DW(DEBT_W)) sd_iss_i (
        .clk(clk), .rst_n(rst_n), .expire(sd_expire), .qual(sd_qual),
        .ack(refresh_ack), .req(sd_req)
    );

    // Merge both issuers onto the bank request lines
    assign refresh_req = pgm_req | sd_req;
endmodule

// File: rtl/rfsh_req_timer_chk.sv
// Assertion checker for the refresh request timer, bound into the top.
// Observes the internal request vectors of each issuer, the programmable-
// machine qualification and the accept lines.
module rfsh_req_timer_chk #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NB-1:0] pgm_req,
    input logic [NB-1:0] sd_req,
    input logic [NB-1:0] pgm_qual,
    input logic [NB-1:0] ack
);
    // R11
    pgm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pgm_req));

    // R11
    sd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sd_req));

    // R8
    pgm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pgm_req != '0) && ((pgm_req & ack) == '0)) |=> (pgm_req == $past(pgm_req)));

    // R8
    sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_req != '0) && ((sd_req & ack) == '0)) |=> (sd_req == $past(sd_req)));

    // R5
    pgm_launch_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pgm_req != '0) && ($past(pgm_req) == '0)) |-> (($past(pgm_qual) & pgm_req) != '0));

    // R7
    sd_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_req & ack) != '0) |=> ((sd_req == '0) || (sd_req > $past(sd_req))));
endmodule

bind rfsh_req_timer rfsh_req_timer_chk #(.NB(NUM_BANKS)) chk_i (
    .clk(clk), .rst_n(rst_n), .pgm_req(pgm_req), .sd_req(sd_req),
    .pgm_qual(pgm_qual), .ack(refresh_ack)
);

// File: tb/rfsh_req_timer_tb_top.sv
// Bench for the refresh request timer. A behavioural reference model
// (integers and a queue) predicts refresh_req, and the prediction is
// compared with the output on every clock. Directed checks cover
// rotation order, round order, intervals and accept handling.
module rfsh_req_timer_tb_top;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] bank_valid = '0, bank_mach = '0, bank_refresh_en = '0;
    logic          presc_wr = 1'b0, pgm_period_wr = 1'b0, sd_period_wr = 1'b0;
    logic [7:0]    presc_wdata = '0, pgm_period_wdata = '0, sd_period_wdata = '0;
    logic [NB-1:0] refresh_ack = '0;
    logic [NB-1:0] refresh_req;

    int    n_checks = 0, n_errors = 0, cyc = 0;
    bit    finished = 1'b0;
    string tag = "R10";

    // Responder controls
    bit rsp_en = 1'b1, bad_ack = 1'b0;
    int ack_delay = 0, wait_c = 0;

    // Rise log: every newly set request bit, with its bank and cycle
    int rise_bank[$], rise_cyc[$];
    logic [NB-1:0] prev_req = '0;

    always #5 clk = ~clk;

    rfsh_req_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bank_valid(bank_valid), .bank_mach(bank_mach),
        .bank_refresh_en(bank_refresh_en), .presc_wr(presc_wr), .presc_wdata(presc_wdata),
        .pgm_period_wr(pgm_period_wr), .pgm_period_wdata(pgm_period_wdata),
        .sd_period_wr(sd_period_wr), .sd_period_wdata(sd_period_wdata),
        .refresh_ack(refresh_ack), .refresh_req(refresh_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // ---------------- reference model ----------------
    int m_pc, m_pa, m_ps, m_uc, m_ua, m_us, m_sc, m_sa, m_ss;
    int m_ubusy, m_ubank, m_ulast, m_udebt, m_sdebt;
    int m_sq[$];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pc = 0; m_pa = 0; m_ps = 0; m_uc = 0; m_ua = 0; m_us = 0;
            m_sc = 0; m_sa = 0; m_ss = 0;
            m_ubusy = 0; m_ubank = 0; m_ulast = NB - 1; m_udebt = 0; m_sdebt = 0;
            m_sq.delete();
        end else begin
            int pdiv, udiv, sdiv;
            bit tk, ue, se, uany, sany;
            bit [NB-1:0] uq, sq;
            pdiv = (m_pa == 0) ? 256 : m_pa;
            udiv = (m_ua == 0) ? 256 : m_ua;
            sdiv = (m_sa == 0) ? 256 : m_sa;
            tk = (m_pc == pdiv - 1);
            ue = tk && (m_uc == udiv - 1);
            se = tk && (m_sc == sdiv - 1);
            for (int b = 0; b < NB; b++) begin
                uq[b] = bank_valid[b] && bank_refresh_en[b] && !bank_mach[b];
                sq[b] = bank_valid[b] && bank_refresh_en[b] && bank_mach[b];
            end
            uany = (uq != 0);
            sany = (sq != 0);
            // programmable machine: one bank per expiry, round-robin
            if (m_ubusy != 0) begin
                if (refresh_ack[m_ubank]) m_ubusy = 0;
                if (ue && uany && m_udebt < 15) m_udebt++;
            end else if ((m_udebt > 0 || ue) && uany) begin
                for (int k = NB; k >= 1; k--)
                    if (uq[(m_ulast + k) % NB]) m_ubank = (m_ulast + k) % NB;
                m_ulast = m_ubank;
                m_ubusy = 1;
                if (!ue) m_udebt--;
            end else if (ue && uany && m_udebt < 15) m_udebt++;
            // SDRAM machine: queue of banks, lowest first
            if (m_sq.size() > 0) begin
                if (refresh_ack[m_sq[0]]) void'(m_sq.pop_front());
                if (se && sany && m_sdebt < 15) m_sdebt++;
            end else if ((m_sdebt > 0 || se) && sany) begin
                for (int b = 0; b < NB; b++) if (sq[b]) m_sq.push_back(b);
                if (!se) m_sdebt--;
            end else if (se && sany && m_sdebt < 15) m_sdebt++;
            // counters
            if (tk) begin
                m_pc = 0; m_pa = m_ps;
                if (ue) begin m_uc = 0; m_ua = m_us; end else m_uc++;
                if (se) begin m_sc = 0; m_sa = m_ss; end else m_sc++;
            end else m_pc++;
            if (presc_wr)      m_ps = presc_wdata;
            if (pgm_period_wr) m_us = pgm_period_wdata;
            if (sd_period_wr)  m_ss = sd_period_wdata;
        end
    end

    // Per-cycle comparison, rise logging and accept responder
    always @(negedge clk) begin
        logic [NB-1:0] expv, a;
        if (rst_n && !finished) begin
            expv = '0;
            if (m_ubusy != 0) expv[m_ubank] = 1'b1;
            if (m_sq.size() > 0) expv[m_sq[0]] = 1'b1;
            chk(refresh_req == expv, tag, "refresh_req vs model", refresh_req, expv);
        end
        for (int b = 0; b < NB; b++)
            if (refresh_req[b] && !prev_req[b]) begin
                rise_bank.push_back(b);
                rise_cyc.push_back(cyc);
            end
        prev_req = refresh_req;
        a = '0;
        if (rsp_en && refresh_req != '0) begin
            if (wait_c >= ack_delay) begin
                a = refresh_req & (~refresh_req + 8'd1);
                wait_c = 0;
            end else wait_c++;
        end else wait_c = 0;
        if (bad_ack) a[3] = 1'b1;
        refresh_ack = a;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_regs(input int pre, input int pgm, input int sd);
        @(negedge clk);
        if (pre >= 0) begin presc_wr = 1'b1; presc_wdata = 8'(pre); end
        if (pgm >= 0) begin pgm_period_wr = 1'b1; pgm_period_wdata = 8'(pgm); end
        if (sd >= 0) begin sd_period_wr = 1'b1; sd_period_wdata = 8'(sd); end
        @(negedge clk);
        presc_wr = 1'b0; pgm_period_wr = 1'b0; sd_period_wr = 1'b0;
    endtask

    task automatic wait_quiet();
        int g = 0;
        while (refresh_req != '0 && g < 2000) begin @(negedge clk); g++; end
    endtask

    task automatic set_cfg(input logic [NB-1:0] v, input logic [NB-1:0] m, input logic [NB-1:0] e);
        wait_quiet();
        bank_valid = v; bank_mach = m; bank_refresh_en = e;
    endtask

    task automatic measure(output int iv);
        int n0 = rise_cyc.size();
        int g = 0;
        while (rise_cyc.size() < n0 + 4 && g < 30000) begin @(negedge clk); g++; end
        iv = (rise_cyc.size() >= n0 + 4) ? rise_cyc[n0 + 3] - rise_cyc[n0 + 2] : -1;
    endtask

    initial begin
        int rel, iv, n0, g;
        int pg[$], sd[$];
        logic [NB-1:0] snap;
        cycles(4);
        // R10: no request while in reset
        chk(refresh_req == '0, "R10", "request during reset", refresh_req, 0);
        rst_n = 1'b1;
        rel = cyc;
        // Banks 0,2,5 programmable; 1 lacks enable; 3 invalid; 4,6 SDRAM; 7 SDRAM without enable
        bank_valid = 8'b1111_0111; bank_mach = 8'b1101_0000; bank_refresh_en = 8'b0111_1101;
        tag = "R3";
        wr_regs(4, 3, 5);
        g = 0;
        while (g < 5000) begin
            pg.delete(); sd.delete();
            foreach (rise_bank[i]) if (bank_mach[rise_bank[i]]) sd.push_back(rise_bank[i]);
                                   else pg.push_back(rise_bank[i]);
            if (pg.size() >= 7 && sd.size() >= 4) break;
            @(negedge clk); g++;
        end
        // R2 / R3: reset values (256 x 256) run until terminal count, so the first expiry is late
        chk(rise_cyc.size() > 0 && rise_cyc[0] - rel >= 1200, "R3", "first request delay",
            rise_cyc.size() > 0 ? rise_cyc[0] - rel : -1, 1276);
        // R10: rotation starts at bank 0
        chk(pg.size() > 0 && pg[0] == 0, "R10", "first rotated bank", pg.size() > 0 ? pg[0] : -1, 0);
        // R5 / R4: rotation 0,2,5 skipping banks 1 and 3
        for (int i = 0; i < 6 && i < pg.size(); i++)
            chk(pg[i] == ((i % 3 == 0) ? 0 : (i % 3 == 1) ? 2 : 5), "R5", "rotation order",
                pg[i], (i % 3 == 0) ? 0 : (i % 3 == 1) ? 2 : 5);
        // R6 / R7: SDRAM rounds cover banks 4 then 6, never bank 7
        for (int i = 0; i < 4 && i < sd.size(); i++)
            chk(sd[i] == ((i % 2 == 0) ? 4 : 6), "R7", "stagger order", sd[i], (i % 2 == 0) ? 4 : 6);
        chk(sd.size() >= 4, "R6", "SDRAM rounds seen", sd.size(), 4);

        // R9: backlog of expiries is kept and drained later
        tag = "R9";
        set_cfg(8'hFF, 8'h00, 8'h25);
        ack_delay = 40;
        cycles(200);
        ack_delay = 0;
        n0 = rise_cyc.size();
        cycles(12);
        chk(rise_cyc.size() - n0 >= 3, "R9", "backlog requests in 12 cycles", rise_cyc.size() - n0, 3);
        cycles(80);

        // R5: no qualified bank gives no request
        tag = "R5";
        set_cfg(8'hFF, 8'h00, 8'h00);
        n0 = rise_cyc.size();
        cycles(100);
        chk(rise_cyc.size() == n0, "R5", "requests with no qualified bank", rise_cyc.size() - n0, 0);

        // R8: accept on an unrequested line is ignored, request held
        tag = "R8";
        bank_refresh_en = 8'h25;
        rsp_en = 1'b0; bad_ack = 1'b1;
        g = 0;
        while (refresh_req == '0 && g < 200) begin @(negedge clk); g++; end
        snap = refresh_req;
        cycles(20);
        chk(snap != '0 && refresh_req == snap, "R8", "request held without accept", refresh_req, snap);
        bad_ack = 1'b0; rsp_en = 1'b1;
        cycles(100);

        // R1: interval is period times prescaler (4 x 3)
        tag = "R1";
        set_cfg(8'hFF, 8'h00, 8'h01);
        cycles(60);
        measure(iv);
        chk(iv == 12, "R1", "interval 4x3", iv, 12);

        // R2: period 0 means 256
        tag = "R2";
        wr_regs(1, 0, -1);
        measure(iv);
        chk(iv == 256, "R2", "interval 1x0", iv, 256);

        // R1: 32 x 128 gives 4096
        tag = "R1";
        wr_regs(32, 128, -1);
        measure(iv);
        chk(iv == 4096, "R1", "interval 32x128", iv, 4096);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(10 * 190000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule